// File: doc/BRIEF.md
# Striped Vector Execution Unit with Chained Functional Units

This block executes element-wise integer vector arithmetic over a bank of vector registers whose elements are interleaved across parallel lanes. Element `i` of every register sits in lane `i mod LANES`, at row `i div LANES` of that lane's slice. A row of one element per lane is called a group. Each cycle a functional unit handles one whole group, one element in every lane. An add unit with a short pipeline and a multiply unit with a longer one can each hold one instruction. Both units can work at the same time.

An instruction names an operation, two source registers and a destination. It runs over elements 0 to VL-1, where VL is a vector length register. Each register keeps a count of how many of its groups have been written. A consumer can therefore begin reading a register while another unit is still producing it. It reads group `g` as soon as that group has landed, and does not wait for the last one. A scalar element port fills and inspects registers, and a per-unit completion pulse marks the end of each instruction.

Top module: `vlane_exec`

## Requirements
- R1: Writing element `i` (0..31) of register `r` through the element load port and then reading `r`,`i` through the read port returns the written value. Elements 5 and 13 of one register are independent, although both sit in lane 5 (groups 0 and 1).
- R2: Opcode 0 (add) writes `vd[i] = vs1[i] + vs2[i]` modulo 2^32 for every `i < VL`.
- R3: Opcode 1 (multiply) writes the low 32 bits of `vs1[i] * vs2[i]` for every `i < VL`.
- R4: Elements `i >= VL` of the destination keep their previous value.
- R5: A VL write above 32 is held as 32. An instruction issued with VL = 0 changes no register, and its completion pulse comes one cycle after acceptance.
- R6: `done[0]` (add) and `done[1]` (multiply) each pulse for one cycle, `G + D` cycles after the accepting clock edge. `G = ceil(VL/8)`, D = 2 for add and 6 for multiply, with no chaining stall.
- R7: A consumer that reads the result of the other unit starts on group `g` as soon as that group is written. For a 32-element multiply followed in the next cycle by a dependent add, the add's `done[0]` comes exactly 3 cycles after the multiply's `done[1]`.
- R8: While a unit holds an instruction, `iss_ready` is low for a new instruction aimed at that unit. This is still true in the cycle its done pulse is high. `iss_ready` rises in the following cycle.
- R9: `iss_ready` is low for an instruction whose destination equals the destination or either source of the instruction held by the other unit. A destination distinct from all three may issue.
- R10: Both units may write their final groups and pulse done in the same cycle, and both results are then correct.
- R11: After reset, `iss_ready` is high, `done` is 0 and every register element reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vl_we | input | 1 | Vector length write strobe |
| vl_in | input | 7 | New vector length, saturated at 32 |
| iss_valid | input | 1 | Instruction present |
| iss_op | input | 1 | 0 = add, 1 = multiply |
| iss_vd | input | 3 | Destination register |
| iss_vs1 | input | 3 | First source register |
| iss_vs2 | input | 3 | Second source register |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| done | output | 2 | Completion pulse, bit 0 add unit, bit 1 multiply unit |
| ld_we | input | 1 | Element load strobe |
| ld_reg | input | 3 | Register to load |
| ld_idx | input | 5 | Element index to load |
| ld_data | input | 32 | Element value |
| rd_reg | input | 3 | Register to read |
| rd_idx | input | 5 | Element index to read |
| rd_data | output | 32 | Element value, combinational |

## Verification
The add and multiply units can both write their last groups into the register bank and raise their done bits in the same cycle. The bench provokes this with a 32-element multiply followed four cycles later by an independent 32-element add, whose shorter pipeline brings its final write onto the multiply's. It then checks that both done bits rise in the same cycle and that every element of both destinations holds its sum or product. The chained case is judged the same way: completion spacing measured in cycles, then full readback of the consumer's destination.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  localparam int VU_DW = 32;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } vop_e;

  // element arithmetic, shared by every lane
  function automatic logic [VU_DW-1:0] vu_alu(input vop_e op,
                                              input logic [VU_DW-1:0] a,
                                              input logic [VU_DW-1:0] b);
    if (op == OP_MUL) return a * b;
    return a + b;
  endfunction

  // number of lane groups covered by a vector length
  function automatic int unsigned vu_groups(input int unsigned vl,
                                            input int unsigned lanes);
    return (vl + lanes - 1) / lanes;
  endfunction

endpackage

// File: rtl/vlane_slice.sv
module vlane_slice
  import vlane_pkg::*;
#(
  parameter int LANE_ID   = 0,
  parameter int LANES     = 8,
  parameter int NREGS     = 8,
  parameter int GROUPS    = 4,
  parameter int ADD_DEPTH = 2,
  parameter int MUL_DEPTH = 6,
  localparam int RW  = $clog2(NREGS),
  localparam int GW  = $clog2(GROUPS),
  localparam int LW  = $clog2(LANES),
  localparam int VLW = $clog2(LANES * GROUPS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_we,
  input  logic [RW-1:0]            ld_reg,
  input  logic [GW-1:0]            ld_grp,
  input  logic [VU_DW-1:0]         ld_data,
  input  logic [RW-1:0]            rd_reg,
  input  logic [GW-1:0]            rd_grp,
  output logic [VU_DW-1:0]         rd_data,
  input  logic [1:0]               launch,
  input  logic [1:0][RW-1:0]       src1,
  input  logic [1:0][RW-1:0]       src2,
  input  logic [1:0][GW-1:0]       lgrp,
  input  logic [1:0]               wr_en,
  input  logic [1:0][RW-1:0]       wr_reg,
  input  logic [1:0][GW-1:0]       wr_grp,
  input  logic [1:0][VLW-1:0]      wr_vl
);

  localparam logic [LW-1:0] LID = LW'(LANE_ID);

  logic [VU_DW-1:0] mem [NREGS][GROUPS];
  logic [1:0][VU_DW-1:0] res;
  logic [1:0] in_len;

  // one data pipeline per unit; unit 0 adds, unit 1 multiplies
  for (genvar u = 0; u < 2; u++) begin : g_unit
    localparam int D = (u == 0) ? ADD_DEPTH : MUL_DEPTH;
    logic [VU_DW-1:0] pipe [D];

    always_ff @(posedge clk) begin
      if (launch[u])
        pipe[0] <= vu_alu(vop_e'(u), mem[src1[u]][lgrp[u]], mem[src2[u]][lgrp[u]]);
      for (int k = 1; k < D; k++) pipe[k] <= pipe[k-1];
    end

    assign res[u]    = pipe[D-1];
    assign in_len[u] = VLW'({wr_grp[u], LID}) < wr_vl[u];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++)
        for (int g = 0; g < GROUPS; g++) mem[r][g] <= '0;
    end else begin
      if (ld_we) mem[ld_reg][ld_grp] <= ld_data;
      for (int u = 0; u < 2; u++)
        if (wr_en[u] && in_len[u]) mem[wr_reg[u]][wr_grp[u]] <= res[u];
    end
  end

  assign rd_data = mem[rd_reg][rd_grp];

endmodule

// File: rtl/vlane_seq.sv
module vlane_seq
  import vlane_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int LANES  = 8,
  parameter int GROUPS = 4,
  parameter int NREGS  = 8,
  localparam int RW  = $clog2(NREGS),
  localparam int GW  = $clog2(GROUPS),
  localparam int CW  = $clog2(GROUPS + 1),
  localparam int VLW = $clog2(LANES * GROUPS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic [RW-1:0]  in_vd,
  input  logic [RW-1:0]  in_vs1,
  input  logic [RW-1:0]  in_vs2,
  input  logic [VLW-1:0] in_vl,
  input  logic           src_ok,
  output logic           busy,
  output logic [RW-1:0]  vd,
  output logic [RW-1:0]  vs1,
  output logic [RW-1:0]  vs2,
  output logic [VLW-1:0] vl,
  output logic           launch,
  output logic [GW-1:0]  launch_grp,
  output logic           wr_en,
  output logic [GW-1:0]  wr_grp,
  output logic           wr_last,
  output logic           done
);

  logic [CW-1:0]    ngrp, nxt;
  logic [DEPTH-1:0] vpipe, lpipe;
  logic [GW-1:0]    gpipe [DEPTH];
  logic             zdone;

  assign launch     = busy && (nxt < ngrp) && src_ok;
  assign launch_grp = nxt[GW-1:0];
  assign wr_en      = vpipe[DEPTH-1];
  assign wr_grp     = gpipe[DEPTH-1];
  assign wr_last    = vpipe[DEPTH-1] && lpipe[DEPTH-1];
  assign done       = wr_last || zdone;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; zdone <= 1'b0; nxt <= '0; ngrp <= '0;
      vd <= '0; vs1 <= '0; vs2 <= '0; vl <= '0;
      vpipe <= '0; lpipe <= '0;
      for (int k = 0; k < DEPTH; k++) gpipe[k] <= '0;
    end else begin
      vpipe[0] <= launch;
      lpipe[0] <= launch && (nxt == ngrp - CW'(1));
      gpipe[0] <= launch_grp;
      for (int k = 1; k < DEPTH; k++) begin
        vpipe[k] <= vpipe[k-1];
        lpipe[k] <= lpipe[k-1];
        gpipe[k] <= gpipe[k-1];
      end
      zdone <= 1'b0;
      if (accept) begin
        vd <= in_vd; vs1 <= in_vs1; vs2 <= in_vs2; vl <= in_vl;
        ngrp  <= CW'(vu_groups(int'(in_vl), LANES));
        nxt   <= '0;
        busy  <= (in_vl != '0);
        zdone <= (in_vl == '0);
      end else begin
        if (launch)  nxt  <= nxt + CW'(1);
        if (wr_last) busy <= 1'b0;
      end
    end
  end

  AST_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy); // R8
  AST_GROUP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_grp == GW'($past(wr_grp) + 1'b1)); // R7
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |=> !busy); // R6

endmodule

// File: rtl/vlane_exec.sv
module vlane_exec
  import vlane_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int ELEMS     = 32,
  parameter int NREGS     = 8,
  parameter int ADD_DEPTH = 2,
  parameter int MUL_DEPTH = 6,
  localparam int GROUPS = ELEMS / LANES,
  localparam int RW  = $clog2(NREGS),
  localparam int EW  = $clog2(ELEMS),
  localparam int LW  = $clog2(LANES),
  localparam int GW  = $clog2(GROUPS),
  localparam int CW  = $clog2(GROUPS + 1),
  localparam int VLW = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vl_we,
  input  logic [VLW:0]     vl_in,
  input  logic             iss_valid,
  input  logic             iss_op,
  input  logic [RW-1:0]    iss_vd,
  input  logic [RW-1:0]    iss_vs1,
  input  logic [RW-1:0]    iss_vs2,
  output logic             iss_ready,
  output logic [1:0]       done,
  input  logic             ld_we,
  input  logic [RW-1:0]    ld_reg,
  input  logic [EW-1:0]    ld_idx,
  input  logic [VU_DW-1:0] ld_data,
  input  logic [RW-1:0]    rd_reg,
  input  logic [EW-1:0]    rd_idx,
  output logic [VU_DW-1:0] rd_data
);

  logic [VLW-1:0]         vl_q;
  logic [CW-1:0]          cnt [NREGS];
  logic [1:0]             busy, acc, src_ok, launch, wr_en, wr_last;
  logic [1:0][RW-1:0]     s_vd, s_vs1, s_vs2;
  logic [1:0][GW-1:0]     l_grp, w_grp;
  logic [1:0][VLW-1:0]    s_vl;
  logic [LANES-1:0][VU_DW-1:0] lane_rd;
  logic                   oth_hazard;

  // vector length register, saturating
  always_ff @(posedge clk) begin
    if (!rst_n)     vl_q <= VLW'(ELEMS);
    else if (vl_we) vl_q <= (vl_in > (VLW+1)'(ELEMS)) ? VLW'(ELEMS) : vl_in[VLW-1:0];
  end

  // issue: one instruction per unit, no WAW/WAR against the other unit
  assign oth_hazard = busy[~iss_op] &&
                      (iss_vd == s_vd[~iss_op] || iss_vd == s_vs1[~iss_op] ||
                       iss_vd == s_vs2[~iss_op]);
  assign iss_ready  = !busy[iss_op] && !oth_hazard;

  for (genvar u = 0; u < 2; u++) begin : g_seq
    assign acc[u] = iss_valid && iss_ready && (iss_op == 1'(u));
    // chaining gate: group g of a source is readable once its count passes g
    assign src_ok[u] = (s_vs1[u] == s_vd[u] || cnt[s_vs1[u]] > CW'(l_grp[u])) &&
                       (s_vs2[u] == s_vd[u] || cnt[s_vs2[u]] > CW'(l_grp[u]));
    vlane_seq #(
      .DEPTH((u == 0) ? ADD_DEPTH : MUL_DEPTH), .LANES(LANES),
      .GROUPS(GROUPS), .NREGS(NREGS)
    ) u_seq (
      .clk(clk), .rst_n(rst_n), .accept(acc[u]),
      .in_vd(iss_vd), .in_vs1(iss_vs1), .in_vs2(iss_vs2), .in_vl(vl_q),
      .src_ok(src_ok[u]), .busy(busy[u]),
      .vd(s_vd[u]), .vs1(s_vs1[u]), .vs2(s_vs2[u]), .vl(s_vl[u]),
      .launch(launch[u]), .launch_grp(l_grp[u]),
      .wr_en(wr_en[u]), .wr_grp(w_grp[u]), .wr_last(wr_last[u]), .done(done[u])
    );
  end

  // per-register written-group progress
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) cnt[r] <= CW'(GROUPS);
    end else begin
      for (int r = 0; r < NREGS; r++) begin
        for (int u = 0; u < 2; u++) begin
          if (wr_en[u] && s_vd[u] == RW'(r))
            cnt[r] <= wr_last[u] ? CW'(GROUPS) : CW'(w_grp[u]) + CW'(1);
          if (acc[u] && vl_q != '0 && iss_vd == RW'(r))
            cnt[r] <= '0;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vlane_slice #(
      .LANE_ID(l), .LANES(LANES), .NREGS(NREGS), .GROUPS(GROUPS),
      .ADD_DEPTH(ADD_DEPTH), .MUL_DEPTH(MUL_DEPTH)
    ) u_slice (
      .clk(clk), .rst_n(rst_n),
      .ld_we(ld_we && ld_idx[LW-1:0] == LW'(l)), .ld_reg(ld_reg),
      .ld_grp(ld_idx[EW-1:LW]), .ld_data(ld_data),
      .rd_reg(rd_reg), .rd_grp(rd_idx[EW-1:LW]), .rd_data(lane_rd[l]),
      .launch(launch), .src1(s_vs1), .src2(s_vs2), .lgrp(l_grp),
      .wr_en(wr_en), .wr_reg(s_vd), .wr_grp(w_grp), .wr_vl(s_vl)
    );
  end

  assign rd_data = lane_rd[rd_idx[LW-1:0]];

  AST_NO_WAW: assert property (@(posedge clk) disable iff (!rst_n)
    busy[0] && busy[1] |-> s_vd[0] != s_vd[1]); // R9
  AST_VL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    vl_we |=> vl_q <= VLW'(ELEMS)); // R5

endmodule

// File: tb/vlane_exec_test.sv
`timescale 1ns/1ps
module vlane_exec_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vl_we = 1'b0;
  logic [6:0]  vl_in = '0;
  logic        iss_valid = 1'b0, iss_op = 1'b0;
  logic [2:0]  iss_vd = '0, iss_vs1 = '0, iss_vs2 = '0;
  logic        iss_ready;
  logic [1:0]  done;
  logic        ld_we = 1'b0;
  logic [2:0]  ld_reg = '0, rd_reg = '0;
  logic [4:0]  ld_idx = '0, rd_idx = '0;
  logic [31:0] ld_data = '0, rd_data;

  int nchk = 0, nfail = 0;
  int ncyc = 0, acc_cyc = 0;
  int done_at [2] = '{0, 0};

  vlane_exec uut (
    .clk(clk), .rst_n(rst_n), .vl_we(vl_we), .vl_in(vl_in),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_vd(iss_vd),
    .iss_vs1(iss_vs1), .iss_vs2(iss_vs2), .iss_ready(iss_ready), .done(done),
    .ld_we(ld_we), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (done[0]) done_at[0] = ncyc;
    if (done[1]) done_at[1] = ncyc;
  end

  // {op, vl, base_a, base_b}
  localparam logic [71:0] VEC [7] = '{
    {1'b0, 7'd32, 32'h0000_0010, 32'h0000_0100},
    {1'b1, 7'd32, 32'h0001_0003, 32'h0000_0007},
    {1'b0, 7'd13, 32'hFFFF_FFF0, 32'h0000_0021},
    {1'b1, 7'd1,  32'h8000_0001, 32'h0000_0003},
    {1'b0, 7'd40, 32'h1234_5678, 32'h0F0F_0F0F},
    {1'b1, 7'd8,  32'hFFFF_FFFF, 32'hFFFF_FFFE},
    {1'b0, 7'd25, 32'h7FFF_FFFF, 32'h0000_0001}
  };

  function automatic logic [31:0] pat_a(input logic [31:0] base, input int i);
    return base + 32'(i) * 32'h01F3_0A07;
  endfunction
  function automatic logic [31:0] pat_b(input logic [31:0] base, input int i);
    return (base ^ (32'(i) << 9)) + 32'(i);
  endfunction
  function automatic logic [31:0] expect_op(input logic op, input logic [31:0] a,
                                            input logic [31:0] b);
    logic [63:0] p;
    logic [32:0] s;
    p = {32'd0, a} * {32'd0, b};
    s = {1'b0, a} + {1'b0, b};
    return op ? p[31:0] : s[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] r, input int i, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_reg = r; ld_idx = 5'(i); ld_data = d;
    @(posedge clk); #1 ld_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] r, input int i, output logic [31:0] d);
    @(negedge clk);
    rd_reg = r; rd_idx = 5'(i);
    #1 d = rd_data;
  endtask

  task automatic set_vl(input int v);
    @(negedge clk); vl_we = 1'b1; vl_in = 7'(v);
    @(posedge clk); #1 vl_we = 1'b0;
  endtask

  task automatic issue(input logic op, input logic [2:0] vd, input logic [2:0] a,
                       input logic [2:0] b);
    @(negedge clk);
    iss_op = op; iss_vd = vd; iss_vs1 = a; iss_vs2 = b; iss_valid = 1'b1;
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    @(posedge clk); acc_cyc = ncyc;
    #1 iss_valid = 1'b0;
  endtask

  task automatic wait_done(input int u, input int since);
    while (done_at[u] <= since) @(posedge clk);
  endtask

  task automatic fill_srcs(input logic [31:0] ba, input logic [31:0] bb);
    for (int i = 0; i < 32; i++) begin
      load(3'd1, i, pat_a(ba, i));
      load(3'd2, i, pat_b(bb, i));
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int a_acc, m_acc, eff, lat;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset state
    @(negedge clk); #1;
    chk("R11 ready", 32'(iss_ready), 32'd1);
    chk("R11 done", 32'(done), 32'd0);
    rd(3'd3, 17, d); chk("R11 reg zero", d, 32'd0);

    // R1: element storage and striping
    load(3'd7, 5, 32'hAAAA_0005);
    load(3'd7, 13, 32'h5555_000D);
    rd(3'd7, 5, d);  chk("R1 elem5", d, 32'hAAAA_0005);
    rd(3'd7, 13, d); chk("R1 elem13", d, 32'h5555_000D);

    // table of vectors: R2 R3 R4 R5 R6
    for (int t = 0; t < 7; t++) begin
      logic op;
      logic [31:0] ba, bb;
      int vl;
      {op, vl, ba, bb} = {VEC[t][71], 32'(VEC[t][70:64]), VEC[t][63:32], VEC[t][31:0]};
      fill_srcs(ba, bb);
      for (int i = 0; i < 32; i++) load(3'd3, i, 32'hDEAD_0000 + 32'(i));
      set_vl(vl);
      eff = (vl > 32) ? 32 : vl;
      issue(op, 3'd3, 3'd1, 3'd2);
      a_acc = acc_cyc;
      wait_done(op ? 1 : 0, a_acc);
      lat = done_at[op ? 1 : 0] - a_acc;
      chk("R6 latency", 32'(lat), 32'((eff + 7) / 8 + (op ? 6 : 2)));
      for (int i = 0; i < 32; i++) begin
        rd(3'd3, i, d);
        if (i < eff)
          chk(vl > 32 ? "R5 clamp" : (op ? "R3 mul" : "R2 add"), d,
              expect_op(op, pat_a(ba, i), pat_b(bb, i)));
        else
          chk("R4 tail kept", d, 32'hDEAD_0000 + 32'(i));
      end
    end

    // R5: zero length
    set_vl(0);
    for (int i = 0; i < 4; i++) load(3'd6, i, 32'hC0DE_0000 + 32'(i));
    issue(1'b0, 3'd6, 3'd1, 3'd2);
    a_acc = acc_cyc;
    wait_done(0, a_acc);
    chk("R5 zero-len done", 32'(done_at[0] - a_acc), 32'd1);
    for (int i = 0; i < 4; i++) begin
      rd(3'd6, i, d); chk("R5 zero-len unchanged", d, 32'hC0DE_0000 + 32'(i));
    end
    set_vl(32);
    fill_srcs(32'h0000_0005, 32'h0000_0300);

    // R7: chained consumer of a multiply result
    issue(1'b1, 3'd3, 3'd1, 3'd2);
    m_acc = acc_cyc;
    issue(1'b0, 3'd4, 3'd3, 3'd1);
    a_acc = acc_cyc;
    chk("R7 back-to-back issue", 32'(a_acc - m_acc), 32'd1);
    wait_done(0, a_acc);
    chk("R7 chain spacing", 32'(done_at[0] - done_at[1]), 32'd3);
    for (int i = 0; i < 32; i++) begin
      rd(3'd4, i, d);
      chk("R7 chained result", d,
          expect_op(1'b1, pat_a(32'h5, i), pat_b(32'h300, i)) + pat_a(32'h5, i));
    end

    // R9: hazards against the busy multiply (vd=3, sources 1,2)
    issue(1'b1, 3'd3, 3'd1, 3'd2);
    m_acc = acc_cyc;
    @(negedge clk);
    iss_op = 1'b0; iss_vs1 = 3'd2; iss_vs2 = 3'd2;
    iss_vd = 3'd1; #1 chk("R9 WAR stall", 32'(iss_ready), 32'd0);
    iss_vd = 3'd3; #1 chk("R9 WAW stall", 32'(iss_ready), 32'd0);
    iss_vd = 3'd5; #1 chk("R9 free dest", 32'(iss_ready), 32'd1);

    // R8: second multiply waits for the first
    iss_op = 1'b1; iss_vd = 3'd6; iss_vs1 = 3'd1; iss_vs2 = 3'd2; iss_valid = 1'b1;
    #1 chk("R8 busy stall", 32'(iss_ready), 32'd0);
    do begin @(negedge clk); #1; end while (!done[1]);
    chk("R8 stall in done cycle", 32'(iss_ready), 32'd0);
    @(negedge clk); #1;
    chk("R8 ready after done", 32'(iss_ready), 32'd1);
    @(posedge clk); m_acc = ncyc;
    #1 iss_valid = 1'b0;
    wait_done(1, m_acc);
    rd(3'd6, 31, d);
    chk("R8 second mul", d, expect_op(1'b1, pat_a(32'h5, 31), pat_b(32'h300, 31)));

    // R10: both units finish in one cycle
    issue(1'b1, 3'd3, 3'd1, 3'd2);
    m_acc = acc_cyc;
    repeat (3) @(posedge clk);
    issue(1'b0, 3'd5, 3'd1, 3'd2);
    a_acc = acc_cyc;
    wait_done(1, m_acc);
    wait_done(0, a_acc);
    chk("R10 same-cycle done", 32'(done_at[0]), 32'(done_at[1]));
    for (int i = 0; i < 32; i += 5) begin
      rd(3'd3, i, d);
      chk("R10 mul result", d, expect_op(1'b1, pat_a(32'h5, i), pat_b(32'h300, i)));
      rd(3'd5, i, d);
      chk("R10 add result", d, expect_op(1'b0, pat_a(32'h5, i), pat_b(32'h300, i)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule